// File: doc/BRIEF.md
# Set/Increment Sweep Boot Sequencer

This block loads an arbitrary byte image into the RAM of a target processor whose boot path offers only two operations per resume: write a fixed fill value (24h) to the current location and advance, or increment the current location and advance. The sequencer holds up to 256 image bytes, loaded through a plain write port. A start pulse launches the run. For each operation the block drives a select level that picks set or increment, then gives an active-low resume pulse. The block raises done once the target RAM holds the image.

Every image byte is first offset by the fill value: t = (byte - 24h) mod 256, which is the same as adding DCh. The first sweep issues a set operation for every location and finds the largest offset value L. Countdown sweeps then run for l = L, L-1, ..., 1. In each countdown sweep, a location whose offset is below l is pinned again at the fill value, and every other location is incremented. Location i is therefore incremented exactly t(i) times and ends at 24h + t(i), which is its image byte.

Top module: `sweep_boot_seq`

## Requirements
- R1: After reset, busy and done are 0, resume_n is 1 and sel is at the set level.
- R2: A write with wr_en high stores wr_data at buffer address wr_addr. A later write to the same address replaces the earlier value.
- R3: The first sweep issues exactly n set operations, one for each location 0..n-1 in order, where n is the length latched at start.
- R4: With L the largest value of (byte - 24h) mod 256 over the n bytes, exactly L countdown sweeps of n operations follow the first sweep, so the run has n*(L+1) operations in total. L can be as large as 255.
- R5: In the countdown sweep with counter l, location i gets a set operation (sel equal to the set level, which is 1 by default) when its offset value is less than l. Otherwise it gets an increment operation (sel equal to the other level).
- R6: When the run ends, a target that applies each operation to a pointer that cycles through 0..n-1 holds exactly the loaded image in locations 0..n-1.
- R7: When every offset value is 0, no countdown sweep runs and done rises right after the first sweep, so the run has n operations.
- R8: Before each operation, sel holds its value for at least SETUP_CLKS cycles before resume_n falls. resume_n then stays low for exactly PULSE_CLKS cycles, and sel does not change while resume_n is low. After resume_n rises, RECOV_CLKS cycles pass before the next operation begins.
- R9: The length input is 9 bits wide and takes values 1 to 256. Both ends of that range run correctly.
- R10: A start pulse while busy is ignored. The run in progress keeps its latched length and its operation count.
- R11: busy is high from the cycle after start until the run ends. done then stays high while the block is idle, until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Image buffer write strobe |
| wr_addr | input | 8 | Image buffer write address |
| wr_data | input | 8 | Image byte to store |
| len | input | 9 | Number of bytes to load, 1 to 256, latched at start |
| start | input | 1 | Starts a run when idle |
| sel | output | 1 | Operation select: set level or increment level |
| resume_n | output | 1 | Active-low resume pulse, one per operation |
| busy | output | 1 | A run is in progress |
| done | output | 1 | The last run has completed |

## Verification
The bench models the target as a RAM array with a wrapping pointer. On every falling edge of resume_n it samples sel and applies the matching operation, then compares the RAM with the image. Several images are used. A mixed image has offsets spread over a small range. An image made only of 24h bytes shows whether the countdown sweeps are skipped. A single 23h byte forces the full 255-sweep countdown and exposes errors in the comparison direction or at the ends of the countdown. A 256-byte image and a 1-byte image exercise the two ends of the length range. A start pulse with a different length in the middle of a run shows whether a start while busy is really ignored. Pulse width and the setup of sel are measured on every operation.

// File: rtl/sweep_boot_seq.sv
module sweep_boot_seq #(
  parameter int          DEPTH      = 256,
  parameter logic [7:0]  FILL       = 8'h24,
  parameter bit          SET_LEVEL  = 1'b1,
  parameter int          SETUP_CLKS = 2,
  parameter int          PULSE_CLKS = 3,
  parameter int          RECOV_CLKS = 2,
  localparam int         AW         = $clog2(DEPTH),
  localparam int         LW         = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [LW-1:0] len,
  input  logic          start,
  output logic          sel,
  output logic          resume_n,
  output logic          busy,
  output logic          done
);

  localparam int TMAX = (SETUP_CLKS > PULSE_CLKS) ?
                        ((SETUP_CLKS > RECOV_CLKS) ? SETUP_CLKS : RECOV_CLKS) :
                        ((PULSE_CLKS > RECOV_CLKS) ? PULSE_CLKS : RECOV_CLKS);
  localparam int TW   = $clog2(TMAX + 1);

  typedef enum logic [1:0] {IDLE, SETUP, PULSE, RECOV} st_t;

  logic [7:0]    img [DEPTH];
  st_t           st;
  logic [TW-1:0] tmr;
  logic [LW-1:0] idx, n_r;
  logic [7:0]    lvl, peak;
  logic          first;

  logic [7:0] ofs, peak_nx;
  logic       is_set, last, tmr_end;

  assign ofs      = img[idx[AW-1:0]] - FILL;
  assign peak_nx  = (ofs > peak) ? ofs : peak;
  assign is_set   = first || (ofs < lvl);
  assign last     = (idx == n_r - 1'b1);
  assign tmr_end  = (tmr == '0);
  assign busy     = (st != IDLE);
  assign resume_n = (st != PULSE);
  assign sel      = (busy && !is_set) ? ~SET_LEVEL : SET_LEVEL;

  always_ff @(posedge clk)
    if (wr_en) img[wr_addr] <= wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= IDLE;
      tmr   <= '0;
      idx   <= '0;
      n_r   <= LW'(1);
      lvl   <= '0;
      peak  <= '0;
      first <= 1'b0;
      done  <= 1'b0;
    end else begin
      case (st)
        IDLE: if (start) begin
          st    <= SETUP;
          tmr   <= TW'(SETUP_CLKS - 1);
          idx   <= '0;
          n_r   <= len;
          peak  <= '0;
          first <= 1'b1;
          done  <= 1'b0;
        end
        SETUP: if (tmr_end) begin
          st  <= PULSE;
          tmr <= TW'(PULSE_CLKS - 1);
        end else tmr <= tmr - 1'b1;
        PULSE: if (tmr_end) begin
          st  <= RECOV;
          tmr <= TW'(RECOV_CLKS - 1);
        end else tmr <= tmr - 1'b1;
        RECOV: if (!tmr_end) tmr <= tmr - 1'b1;
        else begin
          st  <= SETUP;
          tmr <= TW'(SETUP_CLKS - 1);
          if (first) peak <= peak_nx;
          if (!last) idx <= idx + 1'b1;
          else begin
            idx <= '0;
            if (first) begin
              first <= 1'b0;
              lvl   <= peak_nx;
              if (peak_nx == 8'd0) begin
                st   <= IDLE;
                done <= 1'b1;
              end
            end else if (lvl == 8'd1) begin
              st   <= IDLE;
              done <= 1'b1;
            end else lvl <= lvl - 1'b1;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end

  a_r1_idle_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> resume_n);

  a_r8_sel_steady_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !resume_n |-> $stable(sel));

  a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (n_r == $past(n_r)));

  a_r11_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r4_level_counts_down: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !first) |=> (!busy || lvl <= $past(lvl)));

  a_r3_index_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (idx < n_r));

endmodule

// File: tb/test_sweep_boot_seq.sv
module test_sweep_boot_seq;
  localparam int SETUP = 2, PULSE = 3;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       wr_en = 1'b0, start = 1'b0;
  logic [7:0] wr_addr = '0, wr_data = '0;
  logic [8:0] len = 9'd1;
  logic       sel, resume_n, busy, done;

  sweep_boot_seq i_sweep_boot_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .len(len), .start(start), .sel(sel), .resume_n(resume_n), .busy(busy), .done(done));

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  logic [7:0] img [256];
  logic [7:0] tgt [256];
  int ptr = 0, nmod = 1, ops = 0, bad_timing = 0;
  int since = 0, lowcnt = 0, cyc = 0;
  logic prev_res = 1'b1, prev_sel = 1'b1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 190000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
    if (sel != prev_sel) since = 0; else since++;
    if (!resume_n && prev_res) begin
      if (since < SETUP) bad_timing++;
      if (sel) tgt[ptr] = 8'h24; else tgt[ptr] = tgt[ptr] + 8'd1;
      ptr = (ptr + 1) % nmod;
      ops++;
      lowcnt = 1;
    end else if (!resume_n) lowcnt++;
    if (resume_n && !prev_res && lowcnt != PULSE) bad_timing++;
    prev_res = resume_n;
    prev_sel = sel;
  end

  task automatic load(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 8'(i); wr_data = img[i];
    end
    @(negedge clk) wr_en = 1'b0;
  endtask

  task automatic run(input int n, input string tag);
    int lmax = 0;
    int w = 0;
    bit okimg = 1'b1;
    int badi = 0;
    for (int i = 0; i < n; i++)
      if (int'(8'(img[i] - 8'h24)) > lmax) lmax = int'(8'(img[i] - 8'h24));
    for (int i = 0; i < 256; i++) tgt[i] = 8'hA5;
    load(n);
    @(negedge clk);
    ptr = 0; nmod = n; ops = 0; bad_timing = 0;
    len = 9'(n); start = 1'b1;
    @(negedge clk) start = 1'b0;
    check(busy == 1'b1 && done == 1'b0, {tag, " R11 busy during run"}, busy, 1);
    while (!done && w < 150000) begin @(negedge clk); w++; end
    check(done == 1'b1 && busy == 1'b0, {tag, " R11 done at end"}, done, 1);
    check(ops == n * (lmax + 1), {tag, " R3 R4 operation count"}, ops, n * (lmax + 1));
    for (int i = 0; i < n; i++)
      if (tgt[i] !== img[i]) begin okimg = 1'b0; badi = i; end
    check(okimg, {tag, " R6 R5 final image"}, int'(tgt[badi]), int'(img[badi]));
    check(bad_timing == 0, {tag, " R8 pulse timing"}, bad_timing, 0);
    repeat (3) @(negedge clk);
    check(done == 1'b1, {tag, " R11 done held"}, done, 1);
  endtask

  task automatic t_reset();
    check(busy == 0 && done == 0, "R1 reset busy/done", {busy, done}, 0);
    check(resume_n == 1 && sel == 1, "R1 reset resume_n/sel", {resume_n, sel}, 3);
  endtask

  task automatic t_mixed();
    for (int i = 0; i < 8; i++) img[i] = 8'h24 + 8'(i * 3 % 7);
    img[5] = 8'h77;
    load(6);
    img[5] = 8'h2A;
    run(8, "mixed R2");
  endtask

  task automatic t_all_fill();
    for (int i = 0; i < 5; i++) img[i] = 8'h24;
    run(5, "allfill R7");
  endtask

  task automatic t_full_countdown();
    img[0] = 8'h23; img[1] = 8'h24;
    run(2, "worst R4");
  endtask

  task automatic t_max_len();
    for (int i = 0; i < 256; i++) img[i] = 8'h24 + 8'((i * 5) % 8);
    run(256, "len256 R9");
  endtask

  task automatic t_min_len();
    img[0] = 8'h27;
    run(1, "len1 R9");
  endtask

  task automatic t_start_busy();
    int w = 0;
    for (int i = 0; i < 4; i++) img[i] = 8'h24 + 8'(3 - i);
    load(4);
    @(negedge clk);
    ptr = 0; nmod = 4; ops = 0; bad_timing = 0;
    for (int i = 0; i < 4; i++) tgt[i] = 8'h00;
    len = 9'd4; start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (20) @(negedge clk);
    len = 9'd1; start = 1'b1;
    @(negedge clk) start = 1'b0;
    while (!done && w < 10000) begin @(negedge clk); w++; end
    check(ops == 16, "R10 ops after start while busy", ops, 16);
    check(tgt[3] == 8'h24 && tgt[0] == 8'h27, "R10 image after start while busy",
          int'(tgt[0]), 39);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_mixed();
    t_all_fill();
    t_full_countdown();
    t_max_len();
    t_min_len();
    t_start_busy();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule